// File: doc/BRIEF.md
# Two-Input Edge Counter with Result Capture

This block counts activity on two asynchronous digital inputs, A and B, in the system clock domain. Both inputs pass through a synchronizer. A mode code then selects how each cycle's activity on A and B turns into a step of +1, 0 or -1 for a 32-bit accumulator. A capture register holds the last finished measurement. An event flag tells software that a new measurement is ready.

In the windowed modes, a non-zero period value sets the measurement length in clock cycles. At the end of each window the accumulator is copied into the result register. The accumulator is then loaded with the step of that boundary cycle, so no count is lost. With a period of zero, a read strobe copies the accumulator into the result instead. The gated-capture mode ignores the period. It holds the accumulator at zero while B is low, counts A rises while B is high, and captures the count on the falling edge of B.

Top module: `edge_capture_counter`

## Requirements
- R1: After reset, `result` is 0 and `evt` is 0. The accumulator and the window timer are also cleared.
- R2: Mode code 0 adds 1 for each synchronized rising edge of A that occurs while synchronized B is high.
- R3: Mode code 1 adds 1 for each rising edge of A while B is high, and subtracts 1 for each rising edge of A while B is low.
- R4: Mode code 2 adds 1 per rising edge of A. When `diff_en` is 1 it also subtracts 1 per rising edge of B, and the two cancel in the same cycle. When `diff_en` is 0, B is ignored.
- R5: Mode code 3 adds 1 for every cycle in which A is high. When `diff_en` is 1 it also subtracts 1 for every cycle in which B is high.
- R6: In mode codes 0 to 3 with a non-zero `period` of P, every P cycles `result` takes the accumulator value and the accumulator is set to that cycle's step. A full window of constant A-high in mode 3 gives exactly P.
- R7: In mode codes 0 to 3 with `period` = 0, a cycle with `rd_stb` high copies the accumulator into `result`. The result is visible one cycle later.
- R8: Mode code 4 holds the accumulator at 0 while B is low and adds 1 per A rise while B is high. On the falling edge of synchronized B it copies the count into `result` and raises `evt`.
- R9: `evt` rises on every window or B-fall capture and stays high until a cycle with `rd_stb` high. If a capture lands on the same cycle as `rd_stb`, `evt` stays high.
- R10: Each input passes through two synchronizing flops. An A-high pulse that lasts one clock cycle is counted exactly once in mode 3.
- R11: The accumulator and `result` wrap modulo 2^32, so one decrement from 0 gives 0xFFFFFFFF.
- R12: Mode codes 5 to 7 add nothing to the accumulator. They follow the windowed capture rules.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| a_in | input | 1 | Asynchronous input A |
| b_in | input | 1 | Asynchronous input B |
| mode_sel | input | 3 | Counting mode code |
| diff_en | input | 1 | Lets B subtract in mode codes 2 and 3 |
| period | input | 32 | Window length in cycles; 0 means capture on read |
| rd_stb | input | 1 | Read strobe: acknowledges `evt`, and captures when `period` is 0 |
| result | output | 32 | Last captured measurement |
| evt | output | 1 | Set when a new measurement is captured |

## Verification
The assertions assume that `mode_sel`, `diff_en` and `period` change only between measurements. They also assume that a shortened period may leave the timer beyond the new limit, and that the block then ends the window on the next cycle. The stimulus changes the configuration only at segment boundaries, and it applies a reset before most segments. Within a segment A, B and `rd_stb` change freely from cycle to cycle, so edges, levels and reads land on window boundaries and on B falls.

// File: rtl/ecc_pkg.sv
package ecc_pkg;
  typedef enum logic [2:0] {
    M_GATED = 3'd0,
    M_UPDN  = 3'd1,
    M_EDGE  = 3'd2,
    M_LEVEL = 3'd3,
    M_GCAP  = 3'd4
  } mode_e;

  typedef logic signed [1:0] step_t;
endpackage

// File: rtl/ecc_sync.sv
module ecc_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic lvl,
  output logic prev
);
  localparam int W = STAGES + 1;
  logic [W-1:0] sh;

  always_ff @(posedge clk) begin
    if (rst) sh <= '0;
    else     sh <= {sh[W-2:0], din};
  end

  assign lvl  = sh[STAGES-1];
  assign prev = sh[STAGES];

  // R10
  prev_follows_chk: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> prev == $past(lvl));
endmodule

// File: rtl/ecc_step.sv
module ecc_step
  import ecc_pkg::*;
(
  input  logic [2:0] mode_sel,
  input  logic       diff_en,
  input  logic       a_lvl,
  input  logic       a_prev,
  input  logic       b_lvl,
  input  logic       b_prev,
  output step_t      step
);
  logic a_rise, b_rise;
  assign a_rise = a_lvl & ~a_prev;
  assign b_rise = b_lvl & ~b_prev;

  always_comb begin
    step = 2'sd0;
    unique case (mode_e'(mode_sel))
      M_GATED, M_GCAP: step = (a_rise && b_lvl) ? 2'sd1 : 2'sd0;
      M_UPDN:  step = !a_rise ? 2'sd0 : (b_lvl ? 2'sd1 : -2'sd1);
      M_EDGE:  step = 2'(signed'({1'b0, a_rise}) - signed'({1'b0, diff_en & b_rise}));
      M_LEVEL: step = 2'(signed'({1'b0, a_lvl}) - signed'({1'b0, diff_en & b_lvl}));
      default: step = 2'sd0;
    endcase
  end
endmodule

// File: rtl/ecc_window.sv
module ecc_window #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic [CNT_W-1:0] period,
  output logic             tick
);
  logic [CNT_W-1:0] tmr;

  assign tick = run && (tmr >= period - CNT_W'(1));

  always_ff @(posedge clk) begin
    if (rst || !run) tmr <= '0;
    else if (tick)   tmr <= '0;
    else             tmr <= tmr + CNT_W'(1);
  end

  // R6
  window_restart_chk: assert property (@(posedge clk) disable iff (rst)
    tick |=> tmr == '0);

  // R6
  window_advance_chk: assert property (@(posedge clk) disable iff (rst)
    run && !tick |=> tmr == $past(tmr) + CNT_W'(1));
endmodule

// File: rtl/edge_capture_counter.sv
module edge_capture_counter
  import ecc_pkg::*;
#(
  parameter int CNT_W     = 32,
  parameter int SYNC_FLOP = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             a_in,
  input  logic             b_in,
  input  logic [2:0]       mode_sel,
  input  logic             diff_en,
  input  logic [CNT_W-1:0] period,
  input  logic             rd_stb,
  output logic [CNT_W-1:0] result,
  output logic             evt
);
  logic a_lvl, a_prev, b_lvl, b_prev;
  step_t step;
  logic gcap, run, tick, b_fall, cap;
  logic [CNT_W-1:0] acc, z_q, step_ext;
  logic evt_q;

  ecc_sync #(.STAGES(SYNC_FLOP)) sync_a_i (.clk(clk), .rst(rst), .din(a_in), .lvl(a_lvl), .prev(a_prev));
  ecc_sync #(.STAGES(SYNC_FLOP)) sync_b_i (.clk(clk), .rst(rst), .din(b_in), .lvl(b_lvl), .prev(b_prev));

  ecc_step step_i (
    .mode_sel(mode_sel), .diff_en(diff_en),
    .a_lvl(a_lvl), .a_prev(a_prev), .b_lvl(b_lvl), .b_prev(b_prev),
    .step(step)
  );

  assign gcap   = (mode_e'(mode_sel) == M_GCAP);
  assign run    = !gcap && (period != '0);
  assign b_fall = ~b_lvl & b_prev;
  assign cap    = (gcap && b_fall) || tick;

  ecc_window #(.CNT_W(CNT_W)) win_i (
    .clk(clk), .rst(rst), .run(run), .period(period), .tick(tick)
  );

  assign step_ext = CNT_W'(signed'(step));

  always_ff @(posedge clk) begin
    if (rst) begin
      acc   <= '0;
      z_q   <= '0;
      evt_q <= 1'b0;
    end else begin
      if (gcap)      acc <= b_lvl ? acc + step_ext : '0;
      else if (tick) acc <= step_ext;
      else           acc <= acc + step_ext;

      if (cap || (!gcap && period == '0 && rd_stb)) z_q <= acc;

      if (cap)         evt_q <= 1'b1;
      else if (rd_stb) evt_q <= 1'b0;
    end
  end

  assign result = z_q;
  assign evt    = evt_q;

  // R1
  reset_clear_chk: assert property (@(posedge clk)
    rst |=> (z_q == '0 && !evt_q && acc == '0));
  // R9
  evt_hold_chk: assert property (@(posedge clk) disable iff (rst)
    evt_q && !rd_stb |=> evt_q);
  // R9
  evt_on_capture_chk: assert property (@(posedge clk) disable iff (rst)
    cap |=> evt_q);
  // R7
  read_capture_chk: assert property (@(posedge clk) disable iff (rst)
    !gcap && period == '0 && rd_stb |=> z_q == $past(acc));
  // R8
  gate_clear_chk: assert property (@(posedge clk) disable iff (rst)
    gcap && !b_lvl |=> acc == '0);
  // R11
  wrap_down_chk: assert property (@(posedge clk) disable iff (rst)
    !gcap && !tick && step == -2'sd1 && acc == '0 |=> acc == '1);
endmodule

// File: tb/edge_capture_counter_tb.sv
module edge_capture_counter_tb_top;
  localparam int W = 32;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic a_in = 0, b_in = 0, diff_en = 0, rd_stb = 0;
  logic [2:0] mode_sel = 0;
  logic [W-1:0] period = 0;
  logic [W-1:0] result;
  logic evt;

  int checks = 0, errors = 0;
  bit done = 0;

  edge_capture_counter dut_i (
    .clk(clk), .rst(rst), .a_in(a_in), .b_in(b_in), .mode_sel(mode_sel),
    .diff_en(diff_en), .period(period), .rd_stb(rd_stb),
    .result(result), .evt(evt)
  );

  always #2 clk = ~clk;

  // reference state
  logic [2:0] ma = 0, mb = 0;
  logic [W-1:0] m_acc = 0, m_z = 0, m_tmr = 0;
  logic m_evt = 0;

  function automatic int step_of(input logic [2:0] md, input logic df,
                                 input logic al, input logic ap, input logic bl, input logic bp);
    int ar = int'(al & ~ap);
    int br = int'(bl & ~bp);
    case (md)
      3'd0, 3'd4: return (ar != 0 && bl) ? 1 : 0;
      3'd1: return (ar == 0) ? 0 : (bl ? 1 : -1);
      3'd2: return ar - (df ? br : 0);
      3'd3: return int'(al) - (df ? int'(bl) : 0);
      default: return 0;
    endcase
  endfunction

  task automatic model_next();
    int st;
    logic gc, rn, tk, bf;
    logic [W-1:0] a0;
    if (rst) begin
      ma = 0; mb = 0; m_acc = 0; m_z = 0; m_tmr = 0; m_evt = 0;
      return;
    end
    st = step_of(mode_sel, diff_en, ma[1], ma[2], mb[1], mb[2]);
    gc = (mode_sel == 3'd4);
    rn = !gc && period != 0;
    tk = rn && (m_tmr >= period - 1);
    bf = !mb[1] && mb[2];
    a0 = m_acc;
    if (gc)      m_acc = mb[1] ? a0 + W'(st) : 0;
    else if (tk) m_acc = W'(st);
    else         m_acc = a0 + W'(st);
    if ((gc && bf) || tk || (!gc && period == 0 && rd_stb)) m_z = a0;
    if ((gc && bf) || tk) m_evt = 1;
    else if (rd_stb)      m_evt = 0;
    if (!rn || tk) m_tmr = 0; else m_tmr = m_tmr + 1;
    ma = {ma[1:0], a_in};
    mb = {mb[1:0], b_in};
  endtask

  task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic string mode_tag(input logic [2:0] md);
    case (md)
      3'd0: return "R2";
      3'd1: return "R3";
      3'd2: return "R4";
      3'd3: return "R5";
      3'd4: return "R8";
      default: return "R12";
    endcase
  endfunction

  task automatic tick_cycle();
    model_next();
    @(posedge clk);
    @(negedge clk);
    check({mode_tag(mode_sel), (period != 0 && mode_sel != 3'd4) ? "/R6" : "/R7"}, result, m_z);
    check("R9", {31'd0, evt}, {31'd0, m_evt});
  endtask

  task automatic do_reset();
    rst = 1; a_in = 0; b_in = 0; rd_stb = 0;
    tick_cycle(); tick_cycle();
    rst = 0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) tick_cycle();
  endtask

  task automatic pulse_a(input int hi, input int lo);
    a_in = 1; idle(hi);
    a_in = 0; idle(lo);
  endtask

  task automatic read_once();
    rd_stb = 1; tick_cycle(); rd_stb = 0;
  endtask

  initial begin
    #(4 * 200000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2024));
    @(negedge clk);
    do_reset();
    // R1
    check("R1", result, 0);
    check("R1", {31'd0, evt}, 0);

    // R11: decrement from zero in mode 1, read with period 0
    mode_sel = 3'd1; period = 0; b_in = 0;
    pulse_a(3, 4);
    read_once(); idle(1);
    check("R11", result, 32'hFFFF_FFFF);

    // R7 with R2: two gated rises then a read
    do_reset();
    mode_sel = 3'd0; b_in = 1;
    pulse_a(2, 2); pulse_a(2, 4);
    read_once(); idle(1);
    check("R7", result, 2);

    // R8: three rises while B high, capture on B fall
    do_reset();
    mode_sel = 3'd4; b_in = 1; idle(3);
    pulse_a(2, 2); pulse_a(2, 2); pulse_a(2, 2);
    b_in = 0; idle(4);
    check("R8", result, 3);
    check("R8", {31'd0, evt}, 1);
    read_once(); idle(1);
    check("R9", {31'd0, evt}, 0);

    // R6: full window of constant A high
    do_reset();
    mode_sel = 3'd3; diff_en = 0; period = 5; a_in = 1;
    idle(30);
    check("R6", result, 5);
    check("R9", {31'd0, evt}, 1);

    // R10: a one-cycle pulse counted once
    do_reset();
    mode_sel = 3'd3; period = 0;
    pulse_a(1, 5);
    read_once(); idle(1);
    check("R10", result, 1);

    // R4: diff edges cancel when A and B rise together
    do_reset();
    mode_sel = 3'd2; diff_en = 1;
    a_in = 1; b_in = 1; idle(3); a_in = 0; b_in = 0; idle(3);
    pulse_a(2, 3);
    read_once(); idle(1);
    check("R4", result, 1);

    // constrained random segments
    for (int seg = 0; seg < 48; seg++) begin
      if (seg % 4 != 3) do_reset();
      mode_sel = 3'($urandom_range(0, 7));
      diff_en  = 1'($urandom_range(0, 1));
      period   = ($urandom_range(0, 2) == 0) ? 0 : W'($urandom_range(1, 17));
      for (int c = 0; c < 300; c++) begin
        a_in   = 1'($urandom_range(0, 1));
        b_in   = ($urandom_range(0, 3) == 0) ? ~b_in : b_in;
        rd_stb = ($urandom_range(0, 15) == 0);
        tick_cycle();
      end
      rd_stb = 0;
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule